// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an eight-bit bidirectional general-purpose I/O port. Software reaches it over a small register bus and sets the direction of each pin. It writes and reads back an output latch, and it reads the pin levels after they pass through a two-flop synchronizer. It also holds a control register with an active-low global pull-up switch and a port-change flag. Every pin has its own output enable, output value and weak pull-up enable. An input that signals low-voltage programming forces the pull-up of bit 5 off.

The upper four pins have a change detector. Each of those pins that is set as an input is compared against a snapshot. The snapshot is taken each time software reads or writes the pin register. Any difference sets the change flag. The flag cannot be cleared while a difference remains, so software must access the pin register before it clears the flag.

Register map: address 0 is the pin register, address 1 the output latch, address 2 the direction register and address 3 the control register. In the control register, bit 7 is the active-low pull-up enable and bit 0 is the change flag. All other bits read as 0.

Top module: `gpio_chg_port`

## Requirements
- R1: While reset is held and after it ends, the direction register reads 0xFF, the latch reads 0x00 and control reads 0x80. pin_oe and pin_pu_en are 0x00 and chg_flag is 0.
- R2: Writing address 2 sets the direction. A 1 bit makes its pin an input (pin_oe bit 0), and a 0 bit drives the pin (pin_oe bit 1). pin_out always equals the latch.
- R3: Reading address 1 returns the latch contents, not the pin levels. Writing either address 0 or address 1 loads the latch.
- R4: Reading address 0 returns pin_in as captured by two flops, so a change at pin_in is seen after the second rising edge.
- R5: pin_pu_en[i] is 1 only when control bit 7 is 0 and direction bit i is 1.
- R6: When lvp_mode is 1, pin_pu_en[5] is 0 whatever the other controls hold.
- R7: chg_flag is set when the synchronized value of any bit 7:4 configured as an input differs from the snapshot. Bits 3:0 and bits configured as outputs never set it.
- R8: The snapshot is refreshed from the synchronized pins on a read (bus_re) or a write (bus_we) of address 0. Reads of other addresses leave it unchanged.
- R9: Writing control with bit 0 = 0 clears chg_flag only when no mismatch is present. A mismatch in the same cycle keeps the flag set, and writing bit 0 = 1 has no effect on the flag.
- R10: The snapshot and synchronizer load the pin levels during reset, so no flag is raised after reset when the pins are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Pin input levels |
| lvp_mode | input | 1 | Low-voltage programming mode, disables pull-up on bit 5 |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu_en | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Port-change interrupt flag |

## Verification
A corrupted direction or control register shows on pin_oe and pin_pu_en in the cycle after the write. A stale or wrongly refreshed snapshot shows as a flag raised three edges after a steady pin, or as a flag missing three edges after a pin changes. A missing clear guard shows at once as a flag that drops while the upper input pins still differ from the last value read. Synchronizer depth errors move the pin-register read value by one edge, and the bench samples that value on each side of the second edge.

// File: rtl/gpio_chg_port.sv
module gpio_chg_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  input  logic       lvp_mode,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_out,
  output logic [7:0] pin_pu_en,
  output logic       chg_flag
);
  localparam logic [1:0] A_PIN = 2'd0, A_LAT = 2'd1, A_DIR = 2'd2, A_CTL = 2'd3;

  logic [7:0] sync1, sync2, lat_q, dir_q;
  logic [7:4] snap_q;
  logic       pu_n_q, flag_q;
  logic       pin_acc, mismatch;

  assign pin_acc  = (bus_re || bus_we) && bus_addr == A_PIN;
  assign mismatch = |((sync2[7:4] ^ snap_q) & dir_q[7:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= pin_in;
      sync2  <= pin_in;
      snap_q <= pin_in[7:4];
      lat_q  <= '0;
      dir_q  <= '1;
      pu_n_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (pin_acc) snap_q <= sync2[7:4];
      if (bus_we) begin
        case (bus_addr)
          A_PIN, A_LAT: lat_q <= bus_wdata;
          A_DIR:        dir_q <= bus_wdata;
          default:      pu_n_q <= bus_wdata[7];
        endcase
      end
      if (mismatch) flag_q <= 1'b1;
      else if (bus_we && bus_addr == A_CTL && !bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_PIN:   bus_rdata = sync2;
      A_LAT:   bus_rdata = lat_q;
      A_DIR:   bus_rdata = dir_q;
      default: bus_rdata = {pu_n_q, 6'b0, flag_q};
    endcase
  end

  assign pin_oe    = ~dir_q;
  assign pin_out   = lat_q;
  assign pin_pu_en = (pu_n_q ? 8'h00 : dir_q) & ~{2'b00, lvp_mode, 5'b00000};
  assign chg_flag  = flag_q;
endmodule

module gpio_chg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       lvp_mode,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_pu_en,
  input logic       chg_flag
);
  // R5
  pu_off_when_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_en & pin_oe) == 8'h00);
  // R6
  lvp_pu5_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvp_mode |-> !pin_pu_en[5]);
  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2) |=> pin_oe == ~$past(bus_wdata));
  // R3
  lat_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1) |=> (bus_addr != 2'd1 || bus_rdata == $past(bus_wdata)));
  // R9
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_flag) |-> $past(bus_we && bus_addr == 2'd3 && !bus_wdata[0]));
endmodule

bind gpio_chg_port gpio_chg_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvp_mode(lvp_mode),
  .pin_oe(pin_oe), .pin_pu_en(pin_pu_en), .chg_flag(chg_flag)
);

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pin_in = 8'hF0;
  logic       lvp_mode = 1'b0;
  logic [7:0] pin_oe, pin_out, pin_pu_en;
  logic       chg_flag;
  int checks = 0, failures = 0;

  gpio_chg_port i_gpio_chg_port (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pu(logic [7:0] dir, logic pu_n, logic lvp);
    return (pu_n ? 8'h00 : dir) & ~(lvp ? 8'h20 : 8'h00);
  endfunction

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, dir, lat, pins;
    logic pu_n, exp_f;
    void'($urandom(32'd1234));
    step(3);
    peek(2'd2, v); check("R1 dir in reset", v, 8'hFF);
    rst_n = 1'b1;
    step(4);
    peek(2'd2, v); check("R1 dir", v, 8'hFF);
    peek(2'd1, v); check("R1 latch", v, 8'h00);
    peek(2'd3, v); check("R1 ctrl", v, 8'h80);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 pu", pin_pu_en, 8'h00);
    check("R10 no flag after reset", {7'b0, chg_flag}, 8'h00);

    // R3 latch vs pins
    pin_in = 8'h3C; step(3);
    wr(2'd1, 8'hA5);
    peek(2'd1, v); check("R3 latch readback", v, 8'hA5);
    peek(2'd0, v); check("R4 pin read", v, 8'h3C);
    check("R2 pin_out", pin_out, 8'hA5);
    wr(2'd0, 8'h5A);
    peek(2'd1, v); check("R3 pin write loads latch", v, 8'h5A);
    check("R2 pin_out after pin write", pin_out, 8'h5A);

    // R4 two-flop timing
    rd(2'd0, v);
    wr(2'd3, 8'h80);
    pin_in = 8'h3D;
    step(1); peek(2'd0, v); check("R4 one edge old", v, 8'h3C);
    step(1); peek(2'd0, v); check("R4 two edges new", v, 8'h3D);
    step(2);
    check("R7 low bits no flag", {7'b0, chg_flag}, 8'h00);

    // R5 / R6
    wr(2'd2, 8'h0F); wr(2'd3, 8'h01);
    check("R2 oe", pin_oe, 8'hF0);
    check("R5 pu", pin_pu_en, 8'h0F);
    wr(2'd2, 8'hFF);
    check("R5 pu all in", pin_pu_en, 8'hFF);
    lvp_mode = 1'b1; #1;
    check("R6 lvp bit5", pin_pu_en, 8'hDF);
    lvp_mode = 1'b0;

    // R7 output pin excluded
    wr(2'd2, 8'hEF); rd(2'd0, v); wr(2'd3, 8'h00);
    pin_in = 8'h2D; step(4);
    check("R7 output bit excluded", {7'b0, chg_flag}, 8'h00);

    // R8 / R9: flag sticks while mismatch persists
    pin_in = 8'h6D; step(4);
    check("R7 input bit sets flag", {7'b0, chg_flag}, 8'h01);
    wr(2'd3, 8'h00); step(1);
    check("R9 clear blocked by mismatch", {7'b0, chg_flag}, 8'h01);
    rd(2'd1, v); wr(2'd3, 8'h00); step(1);
    check("R8 other read no snapshot", {7'b0, chg_flag}, 8'h01);
    wr(2'd3, 8'h01); step(1);
    check("R9 write 1 no effect", {7'b0, chg_flag}, 8'h01);
    rd(2'd0, v); wr(2'd3, 8'h00); step(1);
    check("R9 clear after read", {7'b0, chg_flag}, 8'h00);
    wr(2'd0, 8'h00); pin_in = 8'h2D; step(4);
    wr(2'd0, 8'h11); wr(2'd3, 8'h00); step(1);
    check("R8 pin write refreshes snapshot", {7'b0, chg_flag}, 8'h00);

    // random
    pins = pin_in;
    for (int it = 0; it < 200; it++) begin
      dir = 8'($urandom); lat = 8'($urandom); pu_n = 1'($urandom);
      lvp_mode = 1'($urandom);
      wr(2'd2, dir); wr(2'd1, lat); wr(2'd3, {pu_n, 7'b0000001});
      #1;
      check("R2 rand oe", pin_oe, ~dir);
      check("R2 rand out", pin_out, lat);
      check("R5 R6 rand pu", pin_pu_en, exp_pu(dir, pu_n, lvp_mode));
      rd(2'd0, v); check("R4 rand pin", v, pins);
      wr(2'd3, {pu_n, 7'b0}); step(1);
      check("R9 rand clear", {7'b0, chg_flag}, 8'h00);
      v = 8'($urandom);
      exp_f = |((v ^ pins) & dir & 8'hF0);
      pin_in = v; pins = v; step(4);
      check("R7 rand flag", {7'b0, chg_flag}, {7'b0, exp_f});
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule